// File: doc/BRIEF.md
# I2C Receive Interrupt and Clock-Hold Controller

This block sits beside the shift engine of an I2C interface. It turns bit-level bus events into interrupt requests for software. It can also ask for SCL to be held low, so that software gets time to react. The shift engine reports four events: the falling SCL edge of the last data bit, the falling edge of the acknowledge clock, START and STOP. It also reports whether the current byte is an address byte and whether the interface is transmitting. Software drives the block through write strobes. There is one for the data register, one for the acknowledge/mode control register, one that sets the pending flag, and one that loads the two interrupt enables.

In normal operation the only receive interrupt comes after the acknowledge clock. With the receive-wait enable set and acknowledge clock generation on, the block also raises an interrupt when the last data bit ends. It then holds SCL low, so that software can inspect the byte and choose the acknowledge value before the acknowledge clock is produced. To restart, software writes the control register and then sets the pending flag. A readable wait flag tells software which of the two interrupt points it is at. A STOP condition can raise an interrupt of its own when enabled.

Top module: `i2c_rx_wait_irq`

## Requirements
- R1: After a synchronous reset, pend_n is 1, wait_flag is 0, scl_hold is 0 and irq is 0. Both enables and the acknowledge clock enable are 0.
- R2: A data write sets wait_flag to 1 one cycle later, but only while rx_is_tx and rx_is_addr are both 0. A control write clears wait_flag one cycle later, and it wins over a data write in the same cycle.
- R3: While rx_is_tx or rx_is_addr is 1, a data write leaves wait_flag unchanged, and a last-bit edge raises no request.
- R4: A last-bit edge raises the wait-phase request: one cycle later pend_n is 0 and scl_hold is 1. This happens only when wait_flag, the receive-wait enable and the acknowledge clock enable are all 1, and no START comes in the same cycle.
- R5: With the acknowledge clock enable at 0, a last-bit edge never drives pend_n low and never raises scl_hold.
- R6: An acknowledge-clock falling edge drives pend_n to 0 one cycle later, whatever the enables are.
- R7: A pending-set write drives pend_n to 1 and scl_hold to 0 one cycle later. If a request event comes in the same cycle, the request wins and pend_n goes to 0.
- R8: A START clears wait_flag and scl_hold one cycle later and leaves pend_n unchanged.
- R9: With the stop-interrupt enable at 1, a STOP gives a one-cycle irq pulse one cycle later and leaves pend_n unchanged. With the enable at 0, a STOP gives no pulse.
- R10: irq is a one-cycle pulse in the same cycle that pend_n goes from 1 to 0. It is 0 at all other times, except for an enabled STOP.
- R11: A configuration write loads the stop-interrupt enable from cfg_stop_ie and the receive-wait enable from cfg_wait_ie. A control write loads the acknowledge clock enable from ctrl_ack_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_last_fall | input | 1 | Falling SCL edge of the last data bit (one-cycle strobe) |
| ev_ack_fall | input | 1 | Falling SCL edge of the acknowledge clock (strobe) |
| ev_start | input | 1 | START detected (strobe) |
| ev_stop | input | 1 | STOP detected (strobe) |
| rx_is_addr | input | 1 | Current byte is the address byte after START |
| rx_is_tx | input | 1 | Interface is transmitting |
| wr_data | input | 1 | Software write to the data register |
| wr_ctrl | input | 1 | Software write to the acknowledge/mode control register |
| ctrl_ack_clk | input | 1 | Acknowledge clock enable value carried by wr_ctrl |
| wr_pend_set | input | 1 | Software write that sets the pending flag to 1 |
| wr_cfg | input | 1 | Software write of the interrupt enables |
| cfg_stop_ie | input | 1 | Stop-interrupt enable value carried by wr_cfg |
| cfg_wait_ie | input | 1 | Receive-wait enable value carried by wr_cfg |
| pend_n | output | 1 | Pending flag, active low (0 = request pending) |
| wait_flag | output | 1 | Internal wait flag, read back at the receive-wait enable position |
| scl_hold | output | 1 | Request to hold SCL low |
| irq | output | 1 | Interrupt request pulse |

## Verification
Every output is a register. The effect of a strobe sampled at one clock edge therefore shows on pend_n, wait_flag, scl_hold and irq right after that same edge, which is one cycle of latency for all results. An irq caused by a falling pend_n shows in the same cycle as the new pend_n value. The bench drives strobes between edges and advances its reference model at each rising edge. It compares all four outputs one time unit after the edge, so each result is checked in exactly the cycle it falls due.

// File: rtl/i2c_rxw_pkg.sv
package i2c_rxw_pkg;
  // Enable bits held by the block.
  typedef struct packed {
    logic stop_ie;
    logic wait_ie;
    logic ack_clk_en;
  } rxw_cfg_t;

  localparam int unsigned CFG_W = $bits(rxw_cfg_t);
endpackage

// File: rtl/rxw_cfg_regs.sv
module rxw_cfg_regs
  import i2c_rxw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_cfg,
  input  logic     cfg_stop_ie,
  input  logic     cfg_wait_ie,
  input  logic     wr_ctrl,
  input  logic     ctrl_ack_clk,
  output rxw_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (wr_cfg) begin
        cfg.stop_ie <= cfg_stop_ie;
        cfg.wait_ie <= cfg_wait_ie;
      end
      if (wr_ctrl) cfg.ack_clk_en <= ctrl_ack_clk;
    end
  end
endmodule

// File: rtl/rxw_wait_track.sv
module rxw_wait_track
  import i2c_rxw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rxw_cfg_t cfg,
  input  logic     ev_last_fall,
  input  logic     ev_start,
  input  logic     rx_is_addr,
  input  logic     rx_is_tx,
  input  logic     wr_data,
  input  logic     wr_ctrl,
  input  logic     wr_pend_set,
  output logic     wait_hit,
  output logic     wait_flag,
  output logic     scl_hold
);
  logic rx_data_phase;

  assign rx_data_phase = !rx_is_tx && !rx_is_addr;
  assign wait_hit = ev_last_fall && !ev_start && rx_data_phase &&
                    wait_flag && cfg.wait_ie && cfg.ack_clk_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_flag <= 1'b0;
      scl_hold  <= 1'b0;
    end else begin
      if (ev_start || wr_ctrl)            wait_flag <= 1'b0;
      else if (wr_data && rx_data_phase)  wait_flag <= 1'b1;

      if (ev_start)         scl_hold <= 1'b0;
      else if (wait_hit)    scl_hold <= 1'b1;
      else if (wr_pend_set) scl_hold <= 1'b0;
    end
  end
endmodule

// File: rtl/rxw_pend_irq.sv
module rxw_pend_irq
  import i2c_rxw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rxw_cfg_t cfg,
  input  logic     wait_hit,
  input  logic     ev_ack_fall,
  input  logic     ev_stop,
  input  logic     wr_pend_set,
  output logic     pend_n,
  output logic     irq
);
  logic pend_n_nxt;

  always_comb begin
    pend_n_nxt = pend_n;
    if (wait_hit || ev_ack_fall) pend_n_nxt = 1'b0;
    else if (wr_pend_set)        pend_n_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_n <= 1'b1;
      irq    <= 1'b0;
    end else begin
      pend_n <= pend_n_nxt;
      irq    <= (pend_n && !pend_n_nxt) || (ev_stop && cfg.stop_ie);
    end
  end
endmodule

// File: rtl/i2c_rx_wait_irq.sv
module i2c_rx_wait_irq
  import i2c_rxw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ev_last_fall,
  input  logic ev_ack_fall,
  input  logic ev_start,
  input  logic ev_stop,
  input  logic rx_is_addr,
  input  logic rx_is_tx,
  input  logic wr_data,
  input  logic wr_ctrl,
  input  logic ctrl_ack_clk,
  input  logic wr_pend_set,
  input  logic wr_cfg,
  input  logic cfg_stop_ie,
  input  logic cfg_wait_ie,
  output logic pend_n,
  output logic wait_flag,
  output logic scl_hold,
  output logic irq
);
  rxw_cfg_t cfg;
  logic     wait_hit;

  rxw_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .cfg_stop_ie(cfg_stop_ie),
    .cfg_wait_ie(cfg_wait_ie), .wr_ctrl(wr_ctrl), .ctrl_ack_clk(ctrl_ack_clk),
    .cfg(cfg)
  );

  rxw_wait_track u_wait (
    .clk(clk), .rst(rst), .cfg(cfg), .ev_last_fall(ev_last_fall),
    .ev_start(ev_start), .rx_is_addr(rx_is_addr), .rx_is_tx(rx_is_tx),
    .wr_data(wr_data), .wr_ctrl(wr_ctrl), .wr_pend_set(wr_pend_set),
    .wait_hit(wait_hit), .wait_flag(wait_flag), .scl_hold(scl_hold)
  );

  rxw_pend_irq u_pend (
    .clk(clk), .rst(rst), .cfg(cfg), .wait_hit(wait_hit),
    .ev_ack_fall(ev_ack_fall), .ev_stop(ev_stop), .wr_pend_set(wr_pend_set),
    .pend_n(pend_n), .irq(irq)
  );
endmodule

// File: rtl/i2c_rx_wait_irq_chk.sv
module i2c_rx_wait_irq_chk (
  input logic clk,
  input logic rst,
  input logic ev_last_fall,
  input logic ev_ack_fall,
  input logic ev_start,
  input logic ev_stop,
  input logic wr_pend_set,
  input logic stop_ie,
  input logic ack_clk_en,
  input logic pend_n,
  input logic wait_flag,
  input logic scl_hold,
  input logic irq
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pend_n && !wait_flag && !scl_hold && !irq));

  a_r5_no_hold_without_ack: assert property (@(posedge clk) disable iff (rst)
    (!ack_clk_en && !scl_hold) |=> !scl_hold);

  a_r6_ack_edge_pends: assert property (@(posedge clk) disable iff (rst)
    ev_ack_fall |=> !pend_n);

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (wr_pend_set && !ev_ack_fall && !ev_last_fall) |=> (pend_n && !scl_hold));

  a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> (!scl_hold && !wait_flag));

  a_r9_stop_irq: assert property (@(posedge clk) disable iff (rst)
    (ev_stop && stop_ie) |=> irq);

  a_r10_irq_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_n) |-> irq);
endmodule

bind i2c_rx_wait_irq i2c_rx_wait_irq_chk u_chk (
  .clk(clk), .rst(rst), .ev_last_fall(ev_last_fall), .ev_ack_fall(ev_ack_fall),
  .ev_start(ev_start), .ev_stop(ev_stop), .wr_pend_set(wr_pend_set),
  .stop_ie(cfg.stop_ie), .ack_clk_en(cfg.ack_clk_en), .pend_n(pend_n),
  .wait_flag(wait_flag), .scl_hold(scl_hold), .irq(irq)
);

// File: tb/i2c_rx_wait_irq_tb_top.sv
`timescale 1ns/1ps
module i2c_rx_wait_irq_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic ev_last_fall, ev_ack_fall, ev_start, ev_stop, rx_is_addr, rx_is_tx;
  logic wr_data, wr_ctrl, ctrl_ack_clk, wr_pend_set, wr_cfg, cfg_stop_ie, cfg_wait_ie;
  logic pend_n, wait_flag, scl_hold, irq;

  int n_chk = 0;
  int n_bad = 0;

  // Reference state.
  bit m_pend, m_wait, m_hold, m_irq, m_sie, m_wie, m_ack;

  always #5 clk = ~clk;

  i2c_rx_wait_irq dut_i (
    .clk(clk), .rst(rst), .ev_last_fall(ev_last_fall), .ev_ack_fall(ev_ack_fall),
    .ev_start(ev_start), .ev_stop(ev_stop), .rx_is_addr(rx_is_addr),
    .rx_is_tx(rx_is_tx), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
    .ctrl_ack_clk(ctrl_ack_clk), .wr_pend_set(wr_pend_set), .wr_cfg(wr_cfg),
    .cfg_stop_ie(cfg_stop_ie), .cfg_wait_ie(cfg_wait_ie), .pend_n(pend_n),
    .wait_flag(wait_flag), .scl_hold(scl_hold), .irq(irq)
  );

  task automatic idle_inputs();
    {ev_last_fall, ev_ack_fall, ev_start, ev_stop, wr_data, wr_ctrl,
     wr_pend_set, wr_cfg} = '0;
  endtask

  task automatic cmp(string tag, string nm, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  // Advance one clock: model reacts to inputs seen at the edge, then compare.
  task automatic step(string tag);
    bit hit, np, dphase;
    @(posedge clk);
    if (rst) begin
      m_pend = 1; m_wait = 0; m_hold = 0; m_irq = 0; m_sie = 0; m_wie = 0; m_ack = 0;
    end else begin
      dphase = !rx_is_tx && !rx_is_addr;
      hit = ev_last_fall && !ev_start && dphase && m_wait && m_wie && m_ack;
      np  = (hit || ev_ack_fall) ? 1'b0 : (wr_pend_set ? 1'b1 : m_pend);
      m_irq  = (m_pend && !np) || (ev_stop && m_sie);
      m_pend = np;
      if (ev_start)         m_hold = 0;
      else if (hit)         m_hold = 1;
      else if (wr_pend_set) m_hold = 0;
      if (ev_start || wr_ctrl)     m_wait = 0;
      else if (wr_data && dphase)  m_wait = 1;
      if (wr_cfg) begin m_sie = cfg_stop_ie; m_wie = cfg_wait_ie; end
      if (wr_ctrl) m_ack = ctrl_ack_clk;
    end
    #1;
    cmp(tag, "pend_n", pend_n, m_pend);
    cmp(tag, "wait_flag", wait_flag, m_wait);
    cmp(tag, "scl_hold", scl_hold, m_hold);
    cmp(tag, "irq", irq, m_irq);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle_inputs();
    rx_is_addr = 0; rx_is_tx = 0; ctrl_ack_clk = 0; cfg_stop_ie = 0; cfg_wait_ie = 0;
    rst = 1;
    @(negedge clk);
    step("R1"); step("R1");
    rst = 0;
    step("R1");

    // R11 load enables, ack clock on
    wr_cfg = 1; cfg_stop_ie = 1; cfg_wait_ie = 1; step("R11");
    wr_ctrl = 1; ctrl_ack_clk = 1; step("R11");

    // R2 data write sets the wait flag; ctrl write clears it; ctrl wins
    wr_data = 1; step("R2");
    wr_ctrl = 1; step("R2");
    wr_data = 1; wr_ctrl = 1; step("R2");
    wr_data = 1; step("R2");

    // R4 wait-phase request and hold
    ev_last_fall = 1; step("R4");
    step("R4");
    // R2 restart: ctrl write clears flag, then pending set releases
    wr_ctrl = 1; step("R2");
    wr_pend_set = 1; step("R7");
    // R6 ack edge second request, R10 irq pulse
    ev_ack_fall = 1; step("R6");
    step("R10");
    wr_pend_set = 1; step("R7");

    // R7 request wins over simultaneous pending set
    wr_pend_set = 1; ev_ack_fall = 1; step("R7");
    wr_pend_set = 1; step("R7");

    // R3 transmit / address: data write ignored, no wait request
    rx_is_tx = 1; wr_data = 1; step("R3");
    ev_last_fall = 1; step("R3");
    rx_is_tx = 0; wr_data = 1; step("R3");
    rx_is_addr = 1; ev_last_fall = 1; step("R3");
    rx_is_addr = 0; step("R3");

    // R8 START clears flag and hold, pend unchanged
    ev_last_fall = 1; step("R4");
    ev_start = 1; step("R8");
    wr_pend_set = 1; step("R7");

    // R5 ack clock disabled: no wait request
    wr_ctrl = 1; ctrl_ack_clk = 0; step("R5");
    wr_data = 1; step("R5");
    ev_last_fall = 1; step("R5");
    step("R5");

    // R9 STOP interrupt with and without enable
    ev_stop = 1; step("R9");
    step("R9");
    wr_cfg = 1; cfg_stop_ie = 0; cfg_wait_ie = 1; step("R11");
    ev_stop = 1; step("R9");
    step("R9");

    // R1 reset mid-operation
    wr_ctrl = 1; ctrl_ack_clk = 1; step("R11");
    wr_data = 1; step("R2");
    ev_last_fall = 1; step("R4");
    rst = 1; step("R1");
    rst = 0; step("R1");
    ev_stop = 1; step("R1");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule